// File: doc/BRIEF.md
# Multi-Queue First-Word-Fall-Through Read Selector

This block is the read side of a small buffer that holds many independent logical queues in one shared storage array. A consumer picks which queue it wants to drain by pulsing a select strobe with a queue number. After a fixed settling time, the oldest unread word of that queue appears on the output bus without any read request, in first-word-fall-through fashion. Each active-low read enable then removes the displayed word, and the next word takes its place.

Changing queues is independent of read enable. Every selection takes a constant two cycles to settle, and an output-valid flag marks when the bus holds real data. A simple write port appends words to the tail of any queue so the buffer can be filled. Each queue keeps its own read and write pointers. Each pointer has one extra bit, which separates the full state from the empty state.

Top module: `mq_fwft_reader`

## Requirements
- R1: After a synchronous active-high reset every queue is empty, queue 0 is selected and settled, `dout_valid` is 0 and `dout` is 0.
- R2: On a clock edge with `wr_en` high, `wr_data` is appended to the tail of queue `wr_q`. A write to a queue that already holds 16 words is dropped and leaves that queue's contents unchanged.
- R3: On a clock edge with `sel_en` high, `sel_q` becomes the selected queue, whatever the level of `rd_en_n`.
- R4: After a selecting edge, `dout_valid` is 0 until the second clock edge after it. From that edge on, the output reflects the new queue.
- R5: While `dout_valid` is 1, `dout` equals the oldest unread word of the selected queue. While `dout_valid` is 0, `dout` is 0. `dout_valid` is 1 exactly when the selection has settled and the selected queue is not empty.
- R6: An edge with `rd_en_n` low and `dout_valid` high removes exactly one word from the selected queue, and the following word is shown after that edge.
- R7: An edge with `rd_en_n` low while `dout_valid` is 0 (empty queue or settling selection) removes nothing.
- R8: Queues are independent. Words written to one queue never appear in another, and each queue returns its words in the order they were written.
- R9: When `sel_en` and an active `rd_en_n` share an edge, the pop applies to the previously selected, settled queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for reads, writes and selection |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_q | input | 5 | Queue number to append to |
| wr_data | input | 36 | Word to append |
| sel_en | input | 1 | Queue select strobe |
| sel_q | input | 5 | Queue number to select |
| rd_en_n | input | 1 | Active-low read enable (pop) |
| dout | output | 36 | Head word of the selected queue, 0 when not valid |
| dout_valid | output | 1 | Output holds a valid head word |

## Verification
The hardest situations to reach from the ports are a select strobe that lands on the same edge as a pop, and a read request that arrives while a selection is still settling. Only these two cases show whether the pop is bound to the old queue and whether settling read enables are discarded. The stimulus holds `rd_en_n` low through whole selection windows and issues selects on edges where the old queue is still popping. It also writes into the queue being drained and overfills one queue past 16 words. A behavioural model with one list per queue is compared against the outputs every cycle.

// File: rtl/mq_pkg.sv
package mq_pkg;
    localparam int NUM_Q  = 32;
    localparam int DATA_W = 36;
    localparam int DEPTH  = 16;
    localparam int SETTLE = 2;

    localparam int Q_W    = $clog2(NUM_Q);
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int PTR_W  = IDX_W + 1;
    localparam int ADDR_W = Q_W + IDX_W;
    localparam int CNT_W  = $clog2(SETTLE + 1);

    typedef logic [Q_W-1:0]    qid_t;
    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        qid_t             q;
        logic [CNT_W-1:0] wait_cnt;
    } sel_state_t;

    function automatic addr_t cell_addr(qid_t q, ptr_t p);
        return {q, p[IDX_W-1:0]};
    endfunction

    function automatic ptr_t fill_level(ptr_t wp, ptr_t rp);
        return ptr_t'(wp - rp);
    endfunction
endpackage

// File: rtl/mq_store.sv
module mq_store
    import mq_pkg::*;
(
    input  logic  clk,
    input  logic  we,
    input  addr_t waddr,
    input  word_t wdata,
    input  addr_t raddr,
    output word_t rdata
);
    localparam int CELLS = NUM_Q * DEPTH;

    word_t cells [CELLS];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/mq_ptr_bank.sv
module mq_ptr_bank
    import mq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  qid_t push_q,
    input  logic pop,
    input  qid_t pop_q,
    output ptr_t wr_ptr_o,
    output logic full_o,
    output ptr_t rd_ptr_o,
    output logic empty_o
);
    ptr_t rptr [NUM_Q];
    ptr_t wptr [NUM_Q];

    for (genvar g = 0; g < NUM_Q; g++) begin : g_queue
        always_ff @(posedge clk) begin
            if (rst) begin
                rptr[g] <= '0;
                wptr[g] <= '0;
            end else begin
                if (pop && pop_q == qid_t'(g))   rptr[g] <= rptr[g] + ptr_t'(1);
                if (push && push_q == qid_t'(g)) wptr[g] <= wptr[g] + ptr_t'(1);
            end
        end
    end

    assign wr_ptr_o = wptr[push_q];
    assign full_o   = fill_level(wptr[push_q], rptr[push_q]) == ptr_t'(DEPTH);
    assign rd_ptr_o = rptr[pop_q];
    assign empty_o  = wptr[pop_q] == rptr[pop_q];

    // R2: an accepted write never lands on a queue that is already full
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        push |-> fill_level(wptr[push_q], rptr[push_q]) < ptr_t'(DEPTH));

    // R7: a pop never targets an empty queue
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
        pop |-> wptr[pop_q] != rptr[pop_q]);

    // R6: a pop advances the read pointer of its queue by exactly one
    assert_pop_advance_R6: assert property (@(posedge clk) disable iff (rst)
        pop |=> rptr[$past(pop_q)] == $past(rptr[pop_q]) + ptr_t'(1));
endmodule

// File: rtl/mq_sel_pipe.sv
module mq_sel_pipe
    import mq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sel_en,
    input  qid_t sel_q,
    output qid_t cur_q,
    output logic ready
);
    sel_state_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '{q: '0, wait_cnt: '0};
        end else if (sel_en) begin
            st <= '{q: sel_q, wait_cnt: CNT_W'(SETTLE)};
        end else if (st.wait_cnt != '0) begin
            st.wait_cnt <= st.wait_cnt - CNT_W'(1);
        end
    end

    assign cur_q = st.q;
    assign ready = st.wait_cnt == '0;

    // R4: the edge after a selection never shows a settled output
    assert_blank_after_select_R4: assert property (@(posedge clk) disable iff (rst)
        sel_en |=> !ready);

    // R3: without a new select the settled queue holds
    assert_hold_selection_R3: assert property (@(posedge clk) disable iff (rst)
        (ready && !sel_en) |=> (ready && $stable(cur_q)));

    // R3: a select strobe loads the requested queue
    assert_select_loads_R3: assert property (@(posedge clk) disable iff (rst)
        sel_en |=> cur_q == $past(sel_q));
endmodule

// File: rtl/mq_fwft_reader.sv
module mq_fwft_reader
    import mq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [4:0]  wr_q,
    input  logic [35:0] wr_data,
    input  logic        sel_en,
    input  logic [4:0]  sel_q,
    input  logic        rd_en_n,
    output logic [35:0] dout,
    output logic        dout_valid
);
    qid_t  cur_q;
    logic  ready;
    ptr_t  wr_ptr;
    ptr_t  rd_ptr;
    logic  full;
    logic  empty;
    logic  push;
    logic  pop;
    word_t head;

    mq_sel_pipe u_sel (
        .clk    (clk),
        .rst    (rst),
        .sel_en (sel_en),
        .sel_q  (qid_t'(sel_q)),
        .cur_q  (cur_q),
        .ready  (ready)
    );

    mq_ptr_bank u_ptrs (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_q   (qid_t'(wr_q)),
        .pop      (pop),
        .pop_q    (cur_q),
        .wr_ptr_o (wr_ptr),
        .full_o   (full),
        .rd_ptr_o (rd_ptr),
        .empty_o  (empty)
    );

    mq_store u_store (
        .clk   (clk),
        .we    (push),
        .waddr (cell_addr(qid_t'(wr_q), wr_ptr)),
        .wdata (word_t'(wr_data)),
        .raddr (cell_addr(cur_q, rd_ptr)),
        .rdata (head)
    );

    assign push       = wr_en && !full;
    assign pop        = !rd_en_n && ready && !empty;
    assign dout_valid = ready && !empty;
    assign dout       = dout_valid ? head : '0;

    // R5: a shown word is never taken from a queue that is still settling
    assert_valid_settled_R5: assert property (@(posedge clk) disable iff (rst)
        dout_valid |-> ready);
endmodule

// File: tb/tb_mq_fwft_reader.sv
module tb_mq_fwft_reader;
    logic        clk = 0;
    logic        rst;
    logic        wr_en;
    logic [4:0]  wr_q;
    logic [35:0] wr_data;
    logic        sel_en;
    logic [4:0]  sel_q;
    logic        rd_en_n;
    logic [35:0] dout;
    logic        dout_valid;

    int tests = 0;
    int fails = 0;
    string phase = "R1";

    logic [35:0] mdl [32][$];
    int cur_m = 0;
    int lat_m = 0;
    int stamp = 0;

    always #10 clk = ~clk;

    mq_fwft_reader dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_q(wr_q), .wr_data(wr_data),
        .sel_en(sel_en), .sel_q(sel_q), .rd_en_n(rd_en_n),
        .dout(dout), .dout_valid(dout_valid)
    );

    task automatic check(string tag, logic [35:0] act, logic [35:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare();
        logic        ev;
        logic [35:0] ed;
        string       tag;
        ev  = (lat_m == 0) && (mdl[cur_m].size() > 0);
        ed  = ev ? mdl[cur_m][0] : 36'h0;
        tag = (lat_m != 0) ? "R4" : phase;
        check({tag, " valid"}, {35'h0, dout_valid}, {35'h0, ev});
        check({tag, " data"}, dout, ed);
    endtask

    task automatic cyc(logic we, int wq, logic se, int sq, logic rn);
        logic [35:0] wd;
        bit wok;
        wd      = {4'(wq), 32'(stamp)};
        stamp++;
        wr_en   = we;
        wr_q    = 5'(wq);
        wr_data = wd;
        sel_en  = se;
        sel_q   = 5'(sq);
        rd_en_n = rn;
        @(posedge clk);
        wok = we && (mdl[wq].size() < 16);
        // R9: the pop binds to the queue settled before this edge
        if (!rn && lat_m == 0 && mdl[cur_m].size() > 0) void'(mdl[cur_m].pop_front());
        if (wok) mdl[wq].push_back(wd);
        if (se) begin
            cur_m = sq;
            lat_m = 2;
        end else if (lat_m > 0) begin
            lat_m--;
        end
        #5;
        compare();
        @(negedge clk);
    endtask

    task automatic idle(int n, logic rn);
        for (int i = 0; i < n; i++) cyc(1'b0, 0, 1'b0, 0, rn);
    endtask

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1; wr_en = 0; wr_q = 0; wr_data = 0; sel_en = 0; sel_q = 0; rd_en_n = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1: empty after reset
        check("R1 valid", {35'h0, dout_valid}, 36'h0);
        check("R1 data", dout, 36'h0);
        phase = "R1";
        idle(2, 1'b0);

        // R2: fill queue 3 with five words and overfill queue 7
        phase = "R2";
        for (int i = 0; i < 5; i++) cyc(1'b1, 3, 1'b0, 0, 1'b1);
        for (int i = 0; i < 18; i++) cyc(1'b1, 7, 1'b0, 0, 1'b1);
        check("R2 overfill", 36'(mdl[7].size()), 36'd16);

        // R3 and R7: select queue 3 while read enable is held low
        phase = "R3";
        cyc(1'b0, 0, 1'b1, 3, 1'b0);
        phase = "R7";
        cyc(1'b0, 0, 1'b0, 0, 1'b0);
        cyc(1'b0, 0, 1'b0, 0, 1'b1);
        check("R7 no pop while settling", 36'(mdl[3].size()), 36'd5);

        // R6: pop two words
        phase = "R6";
        cyc(1'b0, 0, 1'b0, 0, 1'b0);
        cyc(1'b0, 0, 1'b0, 0, 1'b0);
        idle(1, 1'b1);

        // R9: select queue 7 on the same edge as a pop of queue 3
        phase = "R9";
        cyc(1'b0, 0, 1'b1, 7, 1'b0);
        check("R9 pop on old queue", 36'(mdl[3].size()), 36'd2);
        idle(2, 1'b1);

        // R6 and R7: drain queue 7 and keep reading on empty
        phase = "R6";
        for (int i = 0; i < 16; i++) cyc(1'b0, 0, 1'b0, 0, 1'b0);
        phase = "R7";
        idle(3, 1'b0);

        // R8: write into the selected queue and others while reading
        phase = "R8";
        for (int i = 0; i < 400; i++) begin
            int  wq = $urandom_range(0, 31);
            bit  we = ($urandom_range(0, 3) != 0);
            bit  se = ($urandom_range(0, 11) == 0);
            int  sq = (i % 2 == 0) ? 7 : $urandom_range(0, 31);
            bit  rn = ($urandom_range(0, 2) == 0);
            if (i % 3 == 0) wq = cur_m;
            cyc(we, wq, se, sq, rn);
        end

        // R5: visit and drain every queue in turn
        phase = "R5";
        for (int q = 0; q < 32; q++) begin
            cyc(1'b0, 0, 1'b1, q, 1'b1);
            idle(20, 1'b0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule